// File: doc/BRIEF.md
# I/O Translation Unit Control and Status Register Block

This block holds the software-visible configuration and fault state of an I/O address translation unit. Software reaches it through a word-addressed port with a write strobe and a combinational read path. Each register keeps only the bits its write mask allows, and some fields read back as constants. The translation logic, which lives elsewhere, uses the exported enable bit, the page-table base and the decoded base address of the translation window.

The translator reports a failed lookup with a one-cycle strobe. It also supplies the faulting page address and whether the access was a read. The block then loads a fixed status pattern and the address into the two fault registers. Software may overwrite both fault registers to clear them. If a strobe and a software write land in the same cycle, the strobe wins.

Top module: `iotu_csr`

## Requirements
- R1: After reset every register reads zero, with three exceptions: control reads VERSION in bits 31:24, arbitration (word 0x800) reads 0x00000008, and fault status (word 0x400) reads 0x00800000.
- R2: A write to control (word 0x000) keeps only the bits under 0x0000001D. Bits 31:24 of a control read always show the VERSION parameter.
- R3: `win_base` equals 0xFFFFFFFF shifted left by 24+n, where n is control bits 4:2. So n=0 gives 0xFF000000 and n=7 gives 0x80000000.
- R4: `xlate_en` follows control bit 0.
- R5: The table base register (word 0x001) keeps only the bits under 0x07FFFC00, and its value appears on `table_base`.
- R6: The TLB flush register (word 0x005) and the page flush register (word 0x006) keep every written bit.
- R7: The four slot words (0x404 to 0x407) each keep only the bits under 0x00010003. The three kept fields are bypass (bit 0), 8-byte bursts (bit 1) and the bypass address bit (bit 16).
- R8: The arbitration word keeps the bits under 0x001F0000, and its bit 3 always reads 1.
- R9: A fault strobe loads status with 0xC0820000, ORed with 0x00040000 when `flt_is_read` is 1. The same strobe loads the fault address word (0x401) with `flt_page`.
- R10: Software writes to the fault status and fault address words store the full value.
- R11: In a cycle with both a fault strobe and a software write to a fault register, the strobe's values are the ones stored.
- R12: Reads of unmapped words return zero, and writes to unmapped words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Word address for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| flt_stb | input | 1 | Fault capture strobe from the translator |
| flt_is_read | input | 1 | Faulting access was a read |
| flt_page | input | 32 | Faulting page address |
| xlate_en | output | 1 | Translator enable |
| win_base | output | 32 | Base address of the translation window |
| table_base | output | 32 | Page-table base register value |

## Verification
The checks assume that `rd_data` is sampled only while `addr` is held steady and no write or fault strobe is pending. They also assume that every input is a known value once reset is released. The stimulus drives each input on the falling edge and holds it for a full cycle. Only read operations are followed by a comparison, and those operations always keep `wr_en` and `flt_stb` low. Same-cycle collisions between a strobe and a write happen only in the dedicated priority cases, and their results are read back in the cycles that follow.

// File: rtl/iotu_csr_pkg.sv
package iotu_csr_pkg;
    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] OFF_CTRL  = 12'h000;
    localparam logic [AW-1:0] OFF_TBASE = 12'h001;
    localparam logic [AW-1:0] OFF_TLBF  = 12'h005;
    localparam logic [AW-1:0] OFF_PGF   = 12'h006;
    localparam logic [AW-1:0] OFF_FSTAT = 12'h400;
    localparam logic [AW-1:0] OFF_FADDR = 12'h401;
    localparam logic [AW-1:0] OFF_SLOT0 = 12'h404;
    localparam logic [AW-1:0] OFF_ARB   = 12'h800;

    localparam logic [DW-1:0] MSK_CTRL  = 32'h0000_001D;
    localparam logic [DW-1:0] MSK_TBASE = 32'h07FF_FC00;
    localparam logic [DW-1:0] MSK_SLOT  = 32'h0001_0003;
    localparam logic [DW-1:0] MSK_ARB   = 32'h001F_0000;
    localparam logic [DW-1:0] FIX_ARB   = 32'h0000_0008;

    localparam logic [DW-1:0] FSTAT_RST = 32'h0080_0000;
    localparam logic [DW-1:0] FSTAT_HIT = 32'hC082_0000;
    localparam logic [DW-1:0] FSTAT_RD  = 32'h0004_0000;

    localparam int RNG_LSB   = 2;
    localparam int RNG_W     = 3;
    localparam int WIN_LOG2  = 24;
endpackage

// File: rtl/iotu_win_decode.sv
module iotu_win_decode
    import iotu_csr_pkg::*;
#(
    parameter int RW       = RNG_W,
    parameter int MIN_LOG2 = WIN_LOG2
) (
    input  logic [RW-1:0] range_sel,
    output logic [DW-1:0] base
);
    localparam logic [DW-1:0] ALL_ONES = '1;

    always_comb begin
        base = ALL_ONES << (MIN_LOG2 + int'(range_sel));
    end
endmodule

// File: rtl/iotu_fault_word.sv
module iotu_fault_word
    import iotu_csr_pkg::*;
(
    input  logic          is_read,
    output logic [DW-1:0] status
);
    always_comb begin
        status = FSTAT_HIT | (is_read ? FSTAT_RD : '0);
    end
endmodule

// File: rtl/iotu_csr.sv
module iotu_csr
    import iotu_csr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41,
    parameter int         N_SLOTS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          flt_stb,
    input  logic          flt_is_read,
    input  logic [DW-1:0] flt_page,
    output logic          xlate_en,
    output logic [DW-1:0] win_base,
    output logic [DW-1:0] table_base
);
    localparam logic [DW-1:0] VER_WORD = {VERSION, {(DW-8){1'b0}}};

    typedef struct packed {
        logic [DW-1:0]              ctrl;
        logic [DW-1:0]              tbase;
        logic [DW-1:0]              tlbf;
        logic [DW-1:0]              pgf;
        logic [N_SLOTS-1:0][DW-1:0] slot;
        logic [DW-1:0]              arb;
        logic [DW-1:0]              fstat;
        logic [DW-1:0]              faddr;
    } regs_t;

    regs_t s_d, s_q;
    logic [DW-1:0] fault_word;
    logic [DW-1:0] fstat_q, faddr_q;

    iotu_fault_word u_fword (
        .is_read (flt_is_read),
        .status  (fault_word)
    );

    iotu_win_decode #(.RW(RNG_W), .MIN_LOG2(WIN_LOG2)) u_win (
        .range_sel (s_q.ctrl[RNG_LSB +: RNG_W]),
        .base      (win_base)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            unique case (addr)
                OFF_CTRL:  s_d.ctrl  = wr_data & MSK_CTRL;
                OFF_TBASE: s_d.tbase = wr_data & MSK_TBASE;
                OFF_TLBF:  s_d.tlbf  = wr_data;
                OFF_PGF:   s_d.pgf   = wr_data;
                OFF_ARB:   s_d.arb   = wr_data & MSK_ARB;
                OFF_FSTAT: s_d.fstat = wr_data;
                OFF_FADDR: s_d.faddr = wr_data;
                default: ;
            endcase
            for (int i = 0; i < N_SLOTS; i++) begin
                if (addr == OFF_SLOT0 + AW'(i)) begin
                    s_d.slot[i] = wr_data & MSK_SLOT;
                end
            end
        end
        if (flt_stb) begin
            s_d.fstat = fault_word;
            s_d.faddr = flt_page;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.fstat <= FSTAT_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFF_CTRL:  rd_data = VER_WORD | s_q.ctrl;
            OFF_TBASE: rd_data = s_q.tbase;
            OFF_TLBF:  rd_data = s_q.tlbf;
            OFF_PGF:   rd_data = s_q.pgf;
            OFF_ARB:   rd_data = s_q.arb | FIX_ARB;
            OFF_FSTAT: rd_data = s_q.fstat;
            OFF_FADDR: rd_data = s_q.faddr;
            default: ;
        endcase
        for (int i = 0; i < N_SLOTS; i++) begin
            if (addr == OFF_SLOT0 + AW'(i)) begin
                rd_data = s_q.slot[i];
            end
        end
    end

    assign xlate_en   = s_q.ctrl[0];
    assign table_base = s_q.tbase;
    assign fstat_q    = s_q.fstat;
    assign faddr_q    = s_q.faddr;
endmodule

// File: rtl/iotu_csr_chk.sv
module iotu_csr_chk
    import iotu_csr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          wr_bit0,
    input logic          flt_stb,
    input logic          flt_is_read,
    input logic [DW-1:0] flt_page,
    input logic [DW-1:0] rd_data,
    input logic          xlate_en,
    input logic [DW-1:0] win_base,
    input logic [DW-1:0] fstat_q,
    input logic [DW-1:0] faddr_q
);
    a_r2_version_field: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_CTRL) |-> (rd_data[31:24] == VERSION));

    a_r3_window_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base[23:0] == '0) && win_base[31] &&
        ($countones(win_base) >= 1) && ($countones(win_base) <= 8));

    a_r4_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CTRL) |=> (xlate_en == $past(wr_bit0)));

    a_r8_arb_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_ARB) |-> rd_data[3]);

    a_r9_fault_status: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (fstat_q == (32'hC082_0000 |
                                 ($past(flt_is_read) ? 32'h0004_0000 : 32'h0))));

    a_r11_fault_addr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (faddr_q == $past(flt_page)));
endmodule

bind iotu_csr iotu_csr_chk #(.VERSION(VERSION)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_bit0     (wr_data[0]),
    .flt_stb     (flt_stb),
    .flt_is_read (flt_is_read),
    .flt_page    (flt_page),
    .rd_data     (rd_data),
    .xlate_en    (xlate_en),
    .win_base    (win_base),
    .fstat_q     (fstat_q),
    .faddr_q     (faddr_q)
);

// File: tb/sim_iotu_csr.sv
`timescale 1ns/1ps
module sim_iotu_csr;
    localparam logic [7:0] VER = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        flt_stb = 1'b0;
    logic        flt_is_read = 1'b0;
    logic [31:0] flt_page = '0;
    logic        xlate_en;
    logic [31:0] win_base;
    logic [31:0] table_base;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    iotu_csr #(.VERSION(VER), .N_SLOTS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .flt_stb(flt_stb), .flt_is_read(flt_is_read),
        .flt_page(flt_page), .xlate_en(xlate_en), .win_base(win_base),
        .table_base(table_base)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d; flt_stb = 1'b0;
    endtask

    task automatic fault(input logic [31:0] pg, input logic rd,
                         input logic do_wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        flt_stb = 1'b1; flt_page = pg; flt_is_read = rd;
        wr_en = do_wr; addr = a; wr_data = d;
    endtask

    // kind 0: rd_data at a, 1: win_base, 2: xlate_en, 3: table_base
    task automatic expect_item(input int k, input logic [11:0] a,
                               input logic [31:0] e, input string t);
        item_t it;
        @(negedge clk);
        addr = a; wr_en = 1'b0; flt_stb = 1'b0;
        it.kind = k; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        expect_item(0, a, e, t);
    endtask

    initial begin : monitor
        item_t it;
        logic [31:0] act;
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                case (it.kind)
                    0: act = rd_data;
                    1: act = win_base;
                    2: act = {31'b0, xlate_en};
                    default: act = table_base;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(12'h000, {VER, 24'h0}, "R1 ctrl");
        rd(12'h800, 32'h0000_0008, "R1 arb");
        rd(12'h400, 32'h0080_0000, "R1 fstat");
        rd(12'h001, 32'h0, "R1 tbase");
        rd(12'h401, 32'h0, "R1 faddr");
        rd(12'h405, 32'h0, "R1 slot1");
        rd(12'h005, 32'h0, "R1 tlbf");
        expect_item(1, 12'h0, 32'hFF00_0000, "R1 win_base");
        expect_item(2, 12'h0, 32'h0, "R1 xlate_en");

        // R2 R3 R4 control
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, {VER, 24'h0} | 32'h1D, "R2 ctrl mask");
        expect_item(1, 12'h0, 32'h8000_0000, "R3 win n7");
        expect_item(2, 12'h0, 32'h1, "R4 enable on");
        for (int n = 0; n < 8; n++) begin
            wr(12'h000, 32'(n) << 2);
            expect_item(1, 12'h0, 32'hFFFF_FFFF << (24 + n), "R3 window sweep");
            expect_item(2, 12'h0, 32'h0, "R4 enable off");
        end
        wr(12'h000, 32'hFFFF_FF01);
        rd(12'h000, {VER, 24'h0} | 32'h01, "R2 ctrl ver");
        expect_item(2, 12'h0, 32'h1, "R4 enable bit0");

        // R5 table base
        wr(12'h001, 32'hFFFF_FFFF);
        rd(12'h001, 32'h07FF_FC00, "R5 tbase mask");
        expect_item(3, 12'h0, 32'h07FF_FC00, "R5 table_base port");
        wr(12'h001, 32'h1234_5678);
        expect_item(3, 12'h0, 32'h1234_5678 & 32'h07FF_FC00, "R5 table_base pattern");

        // R6 flush registers
        wr(12'h005, 32'hDEAD_BEEF);
        wr(12'h006, 32'h1234_5678);
        rd(12'h005, 32'hDEAD_BEEF, "R6 tlbf");
        rd(12'h006, 32'h1234_5678, "R6 pgf");

        // R7 slots
        for (int i = 0; i < 4; i++) wr(12'h404 + 12'(i), 32'hFFFF_FFF0 | 32'(i));
        for (int i = 0; i < 4; i++)
            rd(12'h404 + 12'(i), (32'hFFFF_FFF0 | 32'(i)) & 32'h0001_0003, "R7 slot");

        // R8 arbitration
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, 32'h001F_0008, "R8 arb all");
        wr(12'h800, 32'h0);
        rd(12'h800, 32'h0000_0008, "R8 arb zero");

        // R9 fault capture, read then write
        fault(32'hABCD_E000, 1'b1, 1'b0, 12'h0, 32'h0);
        rd(12'h400, 32'hC086_0000, "R9 fstat read");
        rd(12'h401, 32'hABCD_E000, "R9 faddr");
        fault(32'h0000_3000, 1'b0, 1'b0, 12'h0, 32'h0);
        rd(12'h400, 32'hC082_0000, "R9 fstat write");

        // R10 software clear
        wr(12'h400, 32'h0);
        wr(12'h401, 32'h5555_AAAA);
        rd(12'h400, 32'h0, "R10 fstat clear");
        rd(12'h401, 32'h5555_AAAA, "R10 faddr write");

        // R11 strobe beats write
        fault(32'h7777_7000, 1'b0, 1'b1, 12'h400, 32'h0);
        rd(12'h400, 32'hC082_0000, "R11 fstat priority");
        fault(32'h1111_2000, 1'b1, 1'b1, 12'h401, 32'h0000_1111);
        rd(12'h401, 32'h1111_2000, "R11 faddr priority");
        rd(12'h400, 32'hC086_0000, "R11 fstat read bit");

        // R12 unmapped
        wr(12'h003, 32'hFFFF_FFFF);
        rd(12'h003, 32'h0, "R12 unmapped read");
        rd(12'h7FF, 32'h0, "R12 unmapped high");
        rd(12'h000, {VER, 24'h0} | 32'h01, "R12 ctrl untouched");
        rd(12'h001, 32'h1234_5678 & 32'h07FF_FC00, "R12 tbase untouched");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule